// File: doc/BRIEF.md
# Gated Toggle Latch Detector

This block watches two single-bit inputs, an enable line and a data line. While the enable line is high, the first change of the data line sets the output. The change may be a rise or a fall. The output then stays high whatever the data line does, and it clears only when the enable line goes low. A change of the enable line is never taken as a data change. The enable line rising while the data line is already high does not set the output.

The block is a clocked, sampled form of a fundamental-mode machine. Both inputs pass through two-flop synchronizers. A data change is found by comparing the synchronized data bit with its value one cycle earlier. The machine holds its state in a two-bit register, and a status port shows that register. The codes are chosen so that no step changes both bits. On the way out of the set state the machine passes through the spare code for one cycle.

Top module: `gated_toggle_latch`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 2'b00 and `z_o` is 0.
- R2: In the armed state (`state_o` = 2'b01), a rise or fall of `x2_i` while `x1_i` stays high moves the state to 2'b11. `z_o` goes high three clock edges after the change.
- R3: In state 2'b11 with `x1_i` high, further changes of `x2_i`, in either direction and any number of them, leave the state at 2'b11 and `z_o` at 1.
- R4: When `x1_i` falls in state 2'b11, the state becomes 2'b10 on the third edge and 2'b00 on the fourth. `z_o` is 0 from the third edge on.
- R5: A rise of `x1_i` never sets `z_o`. This holds when `x2_i` is already high and when `x2_i` changes in the same synchronized cycle. The state goes 2'b00 to 2'b01 (armed) instead.
- R6: The state codes are idle 2'b00, armed 2'b01, set 2'b11 and transient 2'b10. Between consecutive cycles at most one state bit changes.
- R7: `z_o` is 1 exactly when `state_o` is 2'b11.
- R8: The transient code 2'b10 is entered only from 2'b11 and always moves to 2'b00 on the next edge.
- R9: While `x1_i` is low, changes of `x2_i` are ignored: the state stays 2'b00 and `z_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x1_i | input | 1 | Enable line, asynchronous |
| x2_i | input | 1 | Data line whose change is detected, asynchronous |
| z_o | output | 1 | Latched detection output |
| state_o | output | 2 | Current state code {q1,q2} |

## Verification
An input change takes two edges to cross the synchronizer. The state and `z_o` change on the third edge after an input is driven. The transient code lasts one edge further. The bench drives inputs on the falling clock edge and shifts a reference model once per rising edge through the same three-edge delay. It compares `z_o` and `state_o` on the next falling edge, so each expected value is due exactly in the cycle it is sampled.

// File: rtl/gtl_pkg.sv
package gtl_pkg;
  localparam int unsigned STATE_W = 2;

  // {q1,q2}; only single-bit steps between codes
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_SET   = 2'b11,
    ST_DRAIN = 2'b10
  } gtl_state_e;
endpackage

// File: rtl/gtl_sync.sv
module gtl_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/gtl_edge.sv
module gtl_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dat_i,
  output logic en_rise_o,
  output logic dat_chg_o
);
  logic en_q, dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      en_q  <= en_i;
      dat_q <= dat_i;
    end
  end

  assign en_rise_o = en_i & ~en_q;
  assign dat_chg_o = dat_i ^ dat_q;
endmodule

// File: rtl/gtl_fsm.sv
module gtl_fsm
  import gtl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       en_rise_i,
  input  logic       dat_chg_i,
  output gtl_state_e state_o
);
  gtl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (en_i) state_d = ST_ARMED;
      ST_ARMED: begin
        if (!en_i)                        state_d = ST_IDLE;
        else if (dat_chg_i && !en_rise_i) state_d = ST_SET;
      end
      ST_SET:   if (!en_i) state_d = ST_DRAIN;
      ST_DRAIN: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_ONE_BIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q ^ $past(state_q)) <= 1); // R6
  AST_DRAIN_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DRAIN |=> state_q == ST_IDLE); // R8
  AST_DRAIN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DRAIN |-> $past(state_q) == ST_SET); // R8
  AST_SET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SET && en_i) |=> state_q == ST_SET); // R3
  AST_SET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SET && $past(state_q) != ST_SET) |->
      $past(dat_chg_i && en_i && !en_rise_i)); // R2
  AST_EN_LOW_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q != ST_SET); // R9
endmodule

// File: rtl/gated_toggle_latch.sv
module gated_toggle_latch
  import gtl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       x1_i,
  input  logic       x2_i,
  output logic       z_o,
  output logic [1:0] state_o
);
  logic [1:0] raw, synced;
  logic       en_rise, dat_chg;
  gtl_state_e state;

  assign raw = {x2_i, x1_i};

  gtl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  gtl_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (synced[0]),
    .dat_i    (synced[1]),
    .en_rise_o(en_rise),
    .dat_chg_o(dat_chg)
  );

  gtl_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (synced[0]),
    .en_rise_i(en_rise),
    .dat_chg_i(dat_chg),
    .state_o  (state)
  );

  // drain code carries q1=1 but must read as cleared
  assign z_o     = (state == ST_SET);
  assign state_o = state;

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> state_o == 2'b00 && !z_o); // R1
  AST_CLEAR_ON_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced[0] |=> !z_o); // R4
  AST_RISE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> !z_o); // R5
endmodule

// File: tb/tb_gated_toggle_latch.sv
`timescale 1ns/1ps
module tb_gated_toggle_latch;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       x1_i = 1'b0;
  logic       x2_i = 1'b0;
  logic       z_o;
  logic [1:0] state_o;

  int n_run = 0;
  int n_fail = 0;
  string tag = "R1";
  logic [1:0] prev_state = 2'b00;

  // reference model: synchronizer copies plus armed/set/drain flags
  logic a1, a2, a3, b1, b2, b3;
  logic m_armed, m_set, m_drain;

  always #2 clk_i = ~clk_i;

  gated_toggle_latch dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .x1_i(x1_i), .x2_i(x2_i),
    .z_o(z_o), .state_o(state_o)
  );

  function automatic logic [1:0] exp_state();
    if (m_set)   return 2'b11;
    if (m_drain) return 2'b10;
    if (m_armed) return 2'b01;
    return 2'b00;
  endfunction

  task automatic model_reset();
    {a1, a2, a3, b1, b2, b3} = '0;
    {m_armed, m_set, m_drain} = '0;
  endtask

  task automatic model_edge();
    logic en, rise, chg;
    en = a2; rise = a2 & ~a3; chg = b2 ^ b3;
    if (m_drain) m_drain = 1'b0;
    else if (m_set) begin
      if (!en) begin m_set = 1'b0; m_drain = 1'b1; end
    end else if (m_armed) begin
      if (!en) m_armed = 1'b0;
      else if (chg && !rise) begin m_armed = 1'b0; m_set = 1'b1; end
    end else if (en) m_armed = 1'b1;
    a3 = a2; a2 = a1; a1 = x1_i;
    b3 = b2; b2 = b1; b1 = x2_i;
  endtask

  task automatic check(input string t, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic b);
    x1_i = a; x2_i = b;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check({tag, " state"}, state_o, exp_state());
    check("R7 z", {1'b0, z_o}, {1'b0, state_o == 2'b11});
    check("R6 one-bit", {1'b0, $countones(state_o ^ prev_state) <= 1}, 2'b01);
    if (prev_state == 2'b10) check("R8 drain exit", state_o, 2'b00);
    prev_state = state_o;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) step(x1_i, x2_i);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    model_reset();
    repeat (3) @(negedge clk_i);
    check("R1 reset state", state_o, 2'b00);
    check("R1 reset z", {1'b0, z_o}, 2'b00);
    rst_ni = 1'b1;

    tag = "R9";  step(0, 1); step(0, 0); step(0, 1); hold(4);
    check("R9 idle", state_o, 2'b00);
    tag = "R5";  step(1, 1); hold(5);
    check("R5 armed not set", state_o, 2'b01);
    tag = "R2";  step(1, 0); hold(4);
    check("R2 falling x2 sets", {1'b0, z_o}, 2'b01);
    tag = "R3";  step(1, 1); step(1, 0); step(1, 1); hold(3);
    check("R3 still set", state_o, 2'b11);
    tag = "R4";  step(0, 1); step(0, 1);
    check("R4 pre-clear", {1'b0, z_o}, 2'b01);
    step(0, 1);
    check("R4 drain", state_o, 2'b10);
    step(0, 1);
    check("R4 idle", state_o, 2'b00);
    hold(2);
    tag = "R2";  step(1, 1); hold(4); step(1, 0); hold(4);
    tag = "R4";  step(0, 0); hold(5);
    tag = "R2";  step(1, 0); hold(4); step(1, 1); hold(4);
    check("R2 rising x2 sets", state_o, 2'b11);
    tag = "R5";  step(0, 1); hold(5); step(1, 0); hold(5);
    check("R5 simultaneous change", state_o, 2'b01);

    tag = "R2 R3 R4 R5 random";
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 10;
      case (r)
        0:       step(~x1_i, x2_i);
        1, 2:    step(x1_i, ~x2_i);
        3:       step(~x1_i, ~x2_i);
        default: step(x1_i, x2_i);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule